// File: doc/BRIEF.md
# Tone Cadence Timer Controller

This block drives the enable line of a tone oscillator so that a tone can be switched on and off under timer control. It holds two programmable durations: an on-time and an off-time. Each is counted in ticks of an external 125 µs strobe. A single shared counter measures both of them in turn. Software picks one of three behaviours through two timer-enable bits in the control register. With both set, the tone repeats on and off. With only the on-timer set, the tone plays once. With the on-timer clear, the enable bit drives the tone directly.

An optional zero-crossing mode extends each burst beyond its on-time. The tone stays on until the oscillator reports that its output has crossed zero, so that the burst does not end with a dc offset. Two sticky status bits record the end of each on period and the end of each off period. A mask register gates these bits onto a single interrupt line. The block is programmed through a simple write-only register port. Sine synthesis, amplitude scaling and the address decoder are outside this block.

Top module: `tone_cadence_ctrl`

## Requirements
- R1: After reset, `tone_en` is 0, both `irq_sts` bits are 0 and `irq` is 0.
- R2: Control is at address 2, with bit0 = tone enable, bit1 = on-timer enable, bit2 = off-timer enable and bit3 = zero-crossing mode. When bit1 is 0, `tone_en` equals the written bit0 from the clock after the write, and ticks do not change it.
- R3: When bits 1 and 2 are both set, the tone repeats. It is on for the duration at address 0 and off for the duration at address 1. A duration D lasts max(D,1) ticks, and `tone_en` changes on the clock edge that samples the expiring tick.
- R4: A duration programmed as 0 expires on the first tick of its phase.
- R5: When bit1 is set and bit2 is clear, writing bit0 = 1 plays one on period. `tone_en` then stays 0 through any number of further ticks.
- R6: In zero-crossing mode, `tone_en` stays 1 after the on-time expires. It clears on the clock that samples `zero_x` high. A `zero_x` pulse in the same cycle as the expiring tick is not used. The off-time count starts from 0 at that point.
- R7: Status is at address 3. `irq_sts[0]` is set when an on-time expires and `irq_sts[1]` when an off-time expires. The bits are sticky and are cleared by writing 1 to them. A set in the same cycle as a clear wins.
- R8: The mask is at address 4, with bits [1:0] matching the status bits. `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R9: A control write restarts the counter from 0. If the written bit0 is 1, the on phase starts. If bit0 is 0 in repeating mode, the off phase starts, and the tone turns on when that phase expires.
- R10: The counter advances only on cycles with `tick` high. Without ticks, `zero_x` or control writes, `tone_en` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| tick | input | 1 | One-cycle 125 µs time-base strobe |
| zero_x | input | 1 | Oscillator output zero-crossing flag |
| tone_en | output | 1 | Oscillator enable |
| irq_sts | output | 2 | Sticky expiry status: bit0 on-time, bit1 off-time |
| irq | output | 1 | Masked interrupt request |

## Verification
The sequencer is driven with several patterns, and each one separates a different cause for a change in `tone_en`. The repeating pattern uses unequal on and off lengths, so that swapped targets would show. Zero-length durations confirm that expiry happens on the first tick rather than after a wrap. The one-shot run continues ticking long after its burst, so that a sequencer that reloads would show. Zero-crossing runs hold the tone across idle cycles and extra ticks before the `zero_x` pulse, which separates ending on the crossing from ending on the timer. Restart writes in the middle of a count, and gaps with no ticks, show whether the count is tied to control writes and to the tick strobe.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {PH_ON = 2'd0, PH_HOLD = 2'd1, PH_OFF = 2'd2} phase_t;
  localparam int unsigned A_ON_DUR  = 0;
  localparam int unsigned A_OFF_DUR = 1;
  localparam int unsigned A_CTRL    = 2;
  localparam int unsigned A_STS     = 3;
  localparam int unsigned A_MASK    = 4;
  localparam int unsigned N_FLAGS   = 2;
endpackage

// File: rtl/tc_regs.sv
module tc_regs #(
  parameter int unsigned DUR_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DUR_W-1:0]             wr_data,
  input  logic [tc_pkg::N_FLAGS-1:0]   set_flags,
  output logic [DUR_W-1:0]             on_dur,
  output logic [DUR_W-1:0]             off_dur,
  output logic                         on_tmr_en,
  output logic                         off_tmr_en,
  output logic                         zc_mode,
  output logic                         ctrl_wr,
  output logic [tc_pkg::N_FLAGS-1:0]   sts,
  output logic                         irq
);
  import tc_pkg::*;

  logic [N_FLAGS-1:0] mask_q;
  logic [N_FLAGS-1:0] clr_flags;
  logic [N_FLAGS-1:0] hit;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign clr_flags = (wr_en && (wr_addr == ADDR_W'(A_STS))) ? wr_data[N_FLAGS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_dur     <= '0;
      off_dur    <= '0;
      on_tmr_en  <= 1'b0;
      off_tmr_en <= 1'b0;
      zc_mode    <= 1'b0;
      mask_q     <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_ON_DUR))  on_dur  <= wr_data;
      if (wr_addr == ADDR_W'(A_OFF_DUR)) off_dur <= wr_data;
      if (wr_addr == ADDR_W'(A_MASK))    mask_q  <= wr_data[N_FLAGS-1:0];
      if (ctrl_wr) begin
        on_tmr_en  <= wr_data[1];
        off_tmr_en <= wr_data[2];
        zc_mode    <= wr_data[3];
      end
    end
  end

  // Sticky flags, write-1-to-clear; a new event outranks a clear.
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)               sts[g] <= 1'b0;
      else if (set_flags[g]) sts[g] <= 1'b1;
      else if (clr_flags[g]) sts[g] <= 1'b0;
    end
    assign hit[g] = sts[g] & mask_q[g];
  end

  assign irq = |hit;
endmodule

// File: rtl/tc_seq.sv
module tc_seq #(
  parameter int unsigned DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             zero_x,
  input  logic             ctrl_wr,
  input  logic             wr_en_bit,
  input  logic             on_tmr_en,
  input  logic             off_tmr_en,
  input  logic             zc_mode,
  input  logic [DUR_W-1:0] on_dur,
  input  logic [DUR_W-1:0] off_dur,
  output logic             tone_en,
  output logic             holding,
  output logic             on_done,
  output logic             off_done
);
  import tc_pkg::*;

  localparam int unsigned CW = DUR_W + 1;

  phase_t          phase_q;
  logic [DUR_W-1:0] cnt_q;
  logic [CW-1:0]    cnt_inc;
  logic             on_hit, off_hit, on_run, off_run;

  assign cnt_inc = {1'b0, cnt_q} + CW'(1);
  assign on_hit  = cnt_inc >= {1'b0, on_dur};
  assign off_hit = cnt_inc >= {1'b0, off_dur};
  assign on_run  = !ctrl_wr && (phase_q == PH_ON) && tone_en && on_tmr_en && tick;
  assign off_run = !ctrl_wr && (phase_q == PH_OFF) && on_tmr_en && off_tmr_en && tick;
  assign on_done  = on_run && on_hit;
  assign off_done = off_run && off_hit;
  assign holding  = (phase_q == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      tone_en <= 1'b0;
    end else if (ctrl_wr) begin
      tone_en <= wr_en_bit;
      phase_q <= wr_en_bit ? PH_ON : PH_OFF;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_ON: begin
          if (on_run) begin
            if (on_hit) begin
              cnt_q <= '0;
              if (zc_mode) begin
                phase_q <= PH_HOLD;
              end else begin
                phase_q <= PH_OFF;
                tone_en <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_inc[DUR_W-1:0];
            end
          end
        end
        PH_HOLD: begin
          if (zero_x) begin
            tone_en <= 1'b0;
            phase_q <= PH_OFF;
            cnt_q   <= '0;
          end
        end
        default: begin
          if (off_run) begin
            if (off_hit) begin
              tone_en <= 1'b1;
              phase_q <= PH_ON;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_inc[DUR_W-1:0];
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tone_cadence_ctrl.sv
module tone_cadence_ctrl #(
  parameter int unsigned DUR_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DUR_W-1:0]  wr_data,
  input  logic              tick,
  input  logic              zero_x,
  output logic              tone_en,
  output logic [1:0]        irq_sts,
  output logic              irq
);
  logic [DUR_W-1:0] on_dur, off_dur;
  logic             on_tmr_en, off_tmr_en, zc_mode, ctrl_wr;
  logic             holding, on_done, off_done;

  tc_regs #(.DUR_W(DUR_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set_flags({off_done, on_done}),
    .on_dur(on_dur), .off_dur(off_dur), .on_tmr_en(on_tmr_en),
    .off_tmr_en(off_tmr_en), .zc_mode(zc_mode), .ctrl_wr(ctrl_wr),
    .sts(irq_sts), .irq(irq)
  );

  tc_seq #(.DUR_W(DUR_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .zero_x(zero_x), .ctrl_wr(ctrl_wr),
    .wr_en_bit(wr_data[0]), .on_tmr_en(on_tmr_en), .off_tmr_en(off_tmr_en),
    .zc_mode(zc_mode), .on_dur(on_dur), .off_dur(off_dur),
    .tone_en(tone_en), .holding(holding), .on_done(on_done), .off_done(off_done)
  );
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int unsigned DUR_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DUR_W-1:0]  wr_data,
  input logic              tick,
  input logic              zero_x,
  input logic              tone_en,
  input logic [1:0]        irq_sts,
  input logic              irq,
  input logic              holding,
  input logic              on_done,
  input logic              off_done
);
  logic cw, sw;
  assign cw = wr_en && (wr_addr == ADDR_W'(tc_pkg::A_CTRL));
  assign sw = wr_en && (wr_addr == ADDR_W'(tc_pkg::A_STS));

  p_direct_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (cw && !wr_data[1]) |=> (tone_en == $past(wr_data[0])));

  p_hold_keeps_tone_r6: assert property (@(posedge clk) disable iff (rst)
    holding |-> tone_en);

  p_hold_waits_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (holding && !zero_x && !cw) |=> (holding && tone_en));

  p_one_expiry_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({on_done, off_done}));

  p_sticky_on_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_sts[0] && !(sw && wr_data[0])) |=> irq_sts[0]);

  p_sticky_off_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_sts[1] && !(sw && wr_data[1])) |=> irq_sts[1]);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_sts == 2'b00) |-> !irq);

  p_no_tick_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !zero_x && !cw) |=> $stable(tone_en));
endmodule

bind tone_cadence_ctrl tc_checker #(.DUR_W(DUR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tick(tick), .zero_x(zero_x), .tone_en(tone_en), .irq_sts(irq_sts), .irq(irq),
  .holding(holding), .on_done(on_done), .off_done(off_done)
);

// File: tb/test_tone_cadence_ctrl.sv
`timescale 1ns/1ps
module test_tone_cadence_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        zero_x = 1'b0;
  logic        tone_en;
  logic [1:0]  irq_sts;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tone_cadence_ctrl i_tone_cadence_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .zero_x(zero_x), .tone_en(tone_en), .irq_sts(irq_sts), .irq(irq)
  );

  // Behavioural reference: phase 0 = on, 1 = waiting for zero crossing, 2 = off.
  int m_on, m_off, m_cnt, m_ph, m_mask, m_sts;
  bit m_en, m_ta, m_ti, m_zc;

  always @(posedge clk) begin
    int set_bits;
    bit cw;
    set_bits = 0;
    if (rst) begin
      m_on = 0; m_off = 0; m_cnt = 0; m_ph = 2; m_mask = 0; m_sts = 0;
      m_en = 0; m_ta = 0; m_ti = 0; m_zc = 0;
    end else begin
      cw = wr_en && wr_addr == 3'd2;
      if (!cw) begin
        if (m_ph == 0 && m_en && m_ta && tick) begin
          if (m_cnt + 1 >= m_on) begin
            set_bits = 1; m_cnt = 0;
            if (m_zc) m_ph = 1;
            else begin m_ph = 2; m_en = 0; end
          end else m_cnt = m_cnt + 1;
        end else if (m_ph == 1) begin
          if (zero_x) begin m_en = 0; m_ph = 2; m_cnt = 0; end
        end else if (m_ph == 2 && m_ta && m_ti && tick) begin
          if (m_cnt + 1 >= m_off) begin
            set_bits = 2; m_en = 1; m_ph = 0; m_cnt = 0;
          end else m_cnt = m_cnt + 1;
        end
      end
      if (wr_en && wr_addr == 3'd3) m_sts = m_sts & ~int'(wr_data[1:0]);
      m_sts = m_sts | set_bits;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_on = int'(wr_data);
          3'd1: m_off = int'(wr_data);
          3'd4: m_mask = int'(wr_data[1:0]);
          3'd2: begin
            m_en = wr_data[0]; m_ta = wr_data[1]; m_ti = wr_data[2]; m_zc = wr_data[3];
            m_ph = wr_data[0] ? 0 : 2; m_cnt = 0;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 model tone_en", int'(tone_en), int'(m_en));
      check("R7 model irq_sts", int'(irq_sts), m_sts);
      check("R8 model irq", int'(irq), int'((m_sts & m_mask) != 0));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic zpulse();
    @(negedge clk); zero_x = 1'b1;
    @(negedge clk); zero_x = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(4);
    @(negedge clk); rst = 1'b0;
    check("R1 tone_en after reset", int'(tone_en), 0);
    check("R1 irq_sts after reset", int'(irq_sts), 0);
    check("R1 irq after reset", int'(irq), 0);

    // Direct mode
    wr(2, 'b0001);
    check("R2 direct on", int'(tone_en), 1);
    ticks(3);
    check("R2 direct on ignores ticks", int'(tone_en), 1);
    wr(2, 'b0000);
    check("R2 direct off", int'(tone_en), 0);

    // Repeating cadence, on 3 ticks / off 2 ticks
    wr(0, 3); wr(1, 2); wr(4, 3);
    wr(2, 'b0111);
    check("R3 cadence starts on", int'(tone_en), 1);
    ticks(2);
    check("R3 still on before on-time", int'(tone_en), 1);
    ticks(1);
    check("R3 off after on-time", int'(tone_en), 0);
    check("R7 on-expiry flag", int'(irq_sts), 1);
    check("R8 irq raised", int'(irq), 1);
    wr(3, 1);
    check("R7 W1C clears", int'(irq_sts), 0);
    ticks(2);
    check("R3 on after off-time", int'(tone_en), 1);
    check("R7 off-expiry flag", int'(irq_sts), 2);
    ticks(12);
    wr(4, 0);
    check("R8 masked irq low", int'(irq), 0);
    wr(3, 3); wr(4, 3);

    // Zero durations
    wr(0, 0); wr(1, 0);
    wr(2, 'b0111);
    ticks(1);
    check("R4 zero on-time expires first tick", int'(tone_en), 0);
    ticks(1);
    check("R4 zero off-time expires first tick", int'(tone_en), 1);

    // One-shot
    wr(0, 2);
    wr(2, 'b0011);
    ticks(1);
    check("R5 one-shot on", int'(tone_en), 1);
    ticks(1);
    check("R5 one-shot ends", int'(tone_en), 0);
    ticks(6);
    check("R5 one-shot stays off", int'(tone_en), 0);

    // Zero-crossing hold
    wr(0, 1); wr(1, 4);
    wr(2, 'b1111);
    ticks(1);
    check("R6 held after expiry", int'(tone_en), 1);
    ticks(2); idle(5);
    check("R6 still held without crossing", int'(tone_en), 1);
    zpulse();
    check("R6 off at crossing", int'(tone_en), 0);
    ticks(3);
    check("R6 off-time counted from crossing", int'(tone_en), 0);
    ticks(1);
    check("R6 on after off-time", int'(tone_en), 1);

    // No ticks
    wr(2, 'b0111);
    idle(30);
    check("R10 no ticks no change", int'(tone_en), 1);

    // Restart on control write
    wr(0, 5); wr(1, 5);
    wr(2, 'b0111);
    ticks(3);
    wr(2, 'b0111);
    ticks(3);
    check("R9 rewrite restarts count", int'(tone_en), 1);
    wr(2, 'b0110);
    check("R9 start in off phase", int'(tone_en), 0);
    ticks(4);
    check("R9 off phase pending", int'(tone_en), 0);
    ticks(1);
    check("R9 turns on after off phase", int'(tone_en), 1);

    idle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule